// File: doc/BRIEF.md
# Three-Way Spectrum Merge Stage (1536 Bins)

This block finishes a 1536-point transform that has been split into three interleaved 512-point transforms. The sub-spectra P, Q and R come from the samples at positions 3n, 3n+1 and 3n+2 of the original sequence. They arrive one after another on a single complex input stream. The block stores all three groups. It then produces the full 1536-bin spectrum in natural order, one bin per clock with no gaps. A flag marks the first bin of the frame and another marks the last.

Each output bin k is P + W^k·Q + W^2k·R. All three sub-spectra are read at bin k mod 512, and W = exp(-j2π/1536). The twiddle coefficients come from constant tables indexed by k and by 2k mod 1536. Each complex product is rounded back to a fixed grid. The three terms are summed at a width that cannot wrap.

Top module: `fft3_combine`

## Requirements
- R1: Output bin k (0..1535) equals P(m) + X + Y with m = k mod 512. X and Y are the rounded complex products of Q(m) with W^k and of R(m) with W^(2k mod 1536). The sum is given exactly as a 20-bit signed value in out_re/out_im, with the same 15 fractional bits as the 17-bit signed inputs.
- R2: Twiddle W^j is held as two 18-bit signed values: floor(cos(2πj/1536)·65536 + 0.5) for the real part and floor(−sin(2πj/1536)·65536 + 0.5) for the imaginary part. Each real or imaginary part of a product is the exact sum of cross products, plus 32768, shifted right arithmetically by 16.
- R3: Only cycles with in_valid high deliver a sample, and idle cycles may fall anywhere inside a frame. The first 512 accepted samples are P(0..511), the next 512 are Q(0..511) and the last 512 are R(0..511).
- R4: Each output frame is 1536 consecutive cycles of out_valid high, carrying bins 0 to 1535 in ascending order.
- R5: out_start is high only on bin 0 and out_end is high only on bin 1535.
- R6: Bin 0 appears on out_valid at the third rising edge after the edge that accepts the last R sample.
- R7: in_valid is ignored during the 1536 edges that follow acceptance of the last R sample. The edge after that window already accepts P(0) of the next frame.
- R8: An asynchronous low on rst_n clears out_valid, out_start and out_end and discards a partly received frame. The next accepted sample is P(0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_re | input | 17 | Input real part, signed, 15 fractional bits |
| in_im | input | 17 | Input imaginary part, signed, 15 fractional bits |
| out_valid | output | 1 | Output bin present |
| out_start | output | 1 | Marks bin 0 |
| out_end | output | 1 | Marks bin 1535 |
| out_re | output | 20 | Output real part, signed, 15 fractional bits |
| out_im | output | 20 | Output imaginary part, signed, 15 fractional bits |

## Verification
The hardest case to reach from the ports is the hand-off at the end of the output phase. A new frame has to be taken on exactly the edge after the ignore window, while the last bins are still moving through the multiplier pipeline. To reach it, the stimulus drives valid junk data on every one of the 1536 ignored edges and starts the next frame on the very next cycle. A shifted or late acceptance then shows up as wrong bins in the following frame. Other frames use an impulse, full-scale negative values and hashed data with random idle cycles. One reset is applied partway through a frame.

// File: rtl/fft3_pkg.sv
package fft3_pkg;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    localparam real TWO_PI = 6.283185307179586;

    // Fixed-point twiddle part: cosine, or negated sine, rounded half up.
    function automatic int tw_fix(input int idx, input int n, input int frac, input bit want_sin);
        real ang;
        real v;
        ang = TWO_PI * real'(idx) / real'(n);
        v   = want_sin ? -$sin(ang) : $cos(ang);
        return $rtoi($floor(v * (2.0 ** frac) + 0.5));
    endfunction

endpackage

// File: rtl/fft3_bank.sv
module fft3_bank #(
    parameter int DEPTH = 512,
    parameter int DW    = 17,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wre,
    input  logic signed [DW-1:0] wim,
    input  logic [AW-1:0]        raddr,
    output logic signed [DW-1:0] rre,
    output logic signed [DW-1:0] rim
);
    logic [2*DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= {wre, wim};
    end

    assign rre = mem[raddr][2*DW-1:DW];
    assign rim = mem[raddr][DW-1:0];
endmodule

// File: rtl/fft3_twiddle.sv
module fft3_twiddle #(
    parameter int N  = 1536,
    parameter int TW = 18,
    parameter int KW = $clog2(N)
) (
    input  logic [KW-1:0]        idx_a,
    input  logic [KW-1:0]        idx_b,
    output logic signed [TW-1:0] wa_re,
    output logic signed [TW-1:0] wa_im,
    output logic signed [TW-1:0] wb_re,
    output logic signed [TW-1:0] wb_im
);
    typedef logic signed [TW-1:0] rom_t [N];

    function automatic rom_t build_rom(input bit want_sin);
        rom_t r;
        for (int i = 0; i < N; i++) begin
            r[i] = TW'(fft3_pkg::tw_fix(i, N, TW - 2, want_sin));
        end
        return r;
    endfunction

    localparam rom_t COS_ROM = build_rom(1'b0);
    localparam rom_t SIN_ROM = build_rom(1'b1);

    assign wa_re = COS_ROM[idx_a];
    assign wa_im = SIN_ROM[idx_a];
    assign wb_re = COS_ROM[idx_b];
    assign wb_im = SIN_ROM[idx_b];
endmodule

// File: rtl/fft3_cmul.sv
module fft3_cmul #(
    parameter int DW = 17,
    parameter int TW = 18,
    parameter int PW = DW + 2
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic signed [PW-1:0] p_re,
    output logic signed [PW-1:0] p_im
);
    localparam int F  = TW - 2;
    localparam int XW = DW + TW + 1;
    localparam logic signed [XW-1:0] RND = XW'(1) << (F - 1);

    logic signed [XW-1:0] full_re, full_im, sum_re, sum_im;

    always_comb begin
        full_re = a_re * w_re - a_im * w_im;
        full_im = a_re * w_im + a_im * w_re;
        sum_re  = full_re + RND;
        sum_im  = full_im + RND;
        p_re    = sum_re[F +: PW];
        p_im    = sum_im[F +: PW];
    end
endmodule

// File: rtl/fft3_combine.sv
module fft3_combine #(
    parameter int SUBN = 512,
    parameter int DW   = 17,
    parameter int TW   = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_re,
    input  logic signed [DW-1:0]   in_im,
    output logic                   out_valid,
    output logic                   out_start,
    output logic                   out_end,
    output logic signed [DW+2:0]   out_re,
    output logic signed [DW+2:0]   out_im
);
    import fft3_pkg::*;

    localparam int N  = 3 * SUBN;
    localparam int KW = $clog2(N);
    localparam int AW = $clog2(SUBN);
    localparam int PW = DW + 2;
    localparam int OW = DW + 3;

    typedef struct packed {
        phase_e                 phase;
        logic [KW-1:0]          wr_cnt;
        logic [KW-1:0]          rd_k;
        logic                   v1, f1, l1;
        logic signed [DW-1:0]   p1re, p1im, q1re, q1im, r1re, r1im;
        logic signed [TW-1:0]   w1re, w1im, w2re, w2im;
        logic                   v2, f2, l2;
        logic signed [DW-1:0]   p2re, p2im;
        logic signed [PW-1:0]   x2re, x2im, y2re, y2im;
        logic                   v3, f3, l3;
        logic signed [OW-1:0]   ore, oim;
    } st_t;

    st_t st_d, st_q;

    logic [2:0]           wr_en;
    logic [1:0]           wr_bank;
    logic [KW-1:0]        wr_off, rd_off;
    logic [AW-1:0]        waddr, raddr;
    logic [KW:0]          two_k;
    logic [KW-1:0]        tw_b_idx;
    logic signed [DW-1:0] bk_re [3];
    logic signed [DW-1:0] bk_im [3];
    logic signed [TW-1:0] wa_re, wa_im, wb_re, wb_im;
    logic signed [PW-1:0] xq_re, xq_im, yr_re, yr_im;

    // Address split for the write side and the read side.
    always_comb begin
        if (st_q.wr_cnt >= KW'(2 * SUBN)) begin
            wr_bank = 2'd2;
            wr_off  = st_q.wr_cnt - KW'(2 * SUBN);
        end else if (st_q.wr_cnt >= KW'(SUBN)) begin
            wr_bank = 2'd1;
            wr_off  = st_q.wr_cnt - KW'(SUBN);
        end else begin
            wr_bank = 2'd0;
            wr_off  = st_q.wr_cnt;
        end
        if (st_q.rd_k >= KW'(2 * SUBN))  rd_off = st_q.rd_k - KW'(2 * SUBN);
        else if (st_q.rd_k >= KW'(SUBN)) rd_off = st_q.rd_k - KW'(SUBN);
        else                             rd_off = st_q.rd_k;
        waddr    = wr_off[AW-1:0];
        raddr    = rd_off[AW-1:0];
        two_k    = {st_q.rd_k, 1'b0};
        tw_b_idx = (two_k >= (KW+1)'(N)) ? KW'(two_k - (KW+1)'(N)) : two_k[KW-1:0];
    end

    for (genvar b = 0; b < 3; b++) begin : g_bank
        assign wr_en[b] = in_valid && (st_q.phase == PH_FILL) && (wr_bank == 2'(b));
        fft3_bank #(.DEPTH(SUBN), .DW(DW), .AW(AW)) u_bank (
            .clk   (clk),
            .we    (wr_en[b]),
            .waddr (waddr),
            .wre   (in_re),
            .wim   (in_im),
            .raddr (raddr),
            .rre   (bk_re[b]),
            .rim   (bk_im[b])
        );
    end

    fft3_twiddle #(.N(N), .TW(TW), .KW(KW)) u_twiddle (
        .idx_a (st_q.rd_k),
        .idx_b (tw_b_idx),
        .wa_re (wa_re),
        .wa_im (wa_im),
        .wb_re (wb_re),
        .wb_im (wb_im)
    );

    fft3_cmul #(.DW(DW), .TW(TW), .PW(PW)) u_mul_q (
        .a_re (st_q.q1re), .a_im (st_q.q1im),
        .w_re (st_q.w1re), .w_im (st_q.w1im),
        .p_re (xq_re),     .p_im (xq_im)
    );

    fft3_cmul #(.DW(DW), .TW(TW), .PW(PW)) u_mul_r (
        .a_re (st_q.r1re), .a_im (st_q.r1im),
        .w_re (st_q.w2re), .w_im (st_q.w2im),
        .p_re (yr_re),     .p_im (yr_im)
    );

    always_comb begin
        st_d    = st_q;
        st_d.v1 = 1'b0;
        st_d.f1 = 1'b0;
        st_d.l1 = 1'b0;

        // Sequencer: fill three groups, then sweep all bins.
        if (st_q.phase == PH_FILL) begin
            if (in_valid) begin
                if (st_q.wr_cnt == KW'(N - 1)) begin
                    st_d.wr_cnt = '0;
                    st_d.rd_k   = '0;
                    st_d.phase  = PH_DRAIN;
                end else begin
                    st_d.wr_cnt = st_q.wr_cnt + 1'b1;
                end
            end
        end else begin
            st_d.v1   = 1'b1;
            st_d.f1   = (st_q.rd_k == '0);
            st_d.l1   = (st_q.rd_k == KW'(N - 1));
            st_d.p1re = bk_re[0];
            st_d.p1im = bk_im[0];
            st_d.q1re = bk_re[1];
            st_d.q1im = bk_im[1];
            st_d.r1re = bk_re[2];
            st_d.r1im = bk_im[2];
            st_d.w1re = wa_re;
            st_d.w1im = wa_im;
            st_d.w2re = wb_re;
            st_d.w2im = wb_im;
            if (st_q.rd_k == KW'(N - 1)) begin
                st_d.rd_k  = '0;
                st_d.phase = PH_FILL;
            end else begin
                st_d.rd_k = st_q.rd_k + 1'b1;
            end
        end

        // Product stage.
        st_d.v2   = st_q.v1;
        st_d.f2   = st_q.f1;
        st_d.l2   = st_q.l1;
        st_d.p2re = st_q.p1re;
        st_d.p2im = st_q.p1im;
        st_d.x2re = xq_re;
        st_d.x2im = xq_im;
        st_d.y2re = yr_re;
        st_d.y2im = yr_im;

        // Sum stage.
        st_d.v3  = st_q.v2;
        st_d.f3  = st_q.f2;
        st_d.l3  = st_q.l2;
        st_d.ore = OW'(st_q.p2re) + OW'(st_q.x2re) + OW'(st_q.y2re);
        st_d.oim = OW'(st_q.p2im) + OW'(st_q.x2im) + OW'(st_q.y2im);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v3;
    assign out_start = st_q.f3;
    assign out_end   = st_q.l3;
    assign out_re    = st_q.ore;
    assign out_im    = st_q.oim;
endmodule

// File: rtl/fft3_combine_chk.sv
module fft3_combine_chk #(
    parameter int SUBN = 512
) (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic out_start,
    input logic out_end
);
    localparam int N  = 3 * SUBN;
    localparam int CW = $clog2(N) + 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_cnt <= '0;
        else if (out_valid) run_cnt <= out_end ? '0 : run_cnt + 1'b1;
    end

    p_start_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    p_end_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> out_valid);

    p_start_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> (run_cnt == '0));

    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> (run_cnt == CW'(N - 1)));

    p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_end) |=> out_valid);

    p_rise_is_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> out_start);

    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !out_start && !out_end));
endmodule

bind fft3_combine fft3_combine_chk #(.SUBN(SUBN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_end   (out_end)
);

// File: tb/test_fft3_combine.sv
`timescale 1ns/1ps
module test_fft3_combine;
    localparam int SUBN = 512;
    localparam int N    = 3 * SUBN;
    localparam int DW   = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic out_valid, out_start, out_end;
    logic signed [DW+2:0] out_re, out_im;

    fft3_combine #(.SUBN(SUBN), .DW(DW), .TW(18)) i_fft3_combine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_start(out_start), .out_end(out_end),
        .out_re(out_re), .out_im(out_im)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    longint tw_re [N];
    longint tw_im [N];
    int exp_re_q [$];
    int exp_im_q [$];
    int buf_re [N];
    int buf_im [N];
    int negcnt = 0, last_neg = -100, out_idx = 0;
    logic last_flag = 1'b0;
    bit finished = 1'b0;
    int seed = 1;

    function automatic void check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, expv, $time);
        end
    endfunction

    function automatic longint rnd16(longint x);
        return (x + 64'sd32768) >>> 16;
    endfunction

    function automatic int hashv(int a, int b);
        int h;
        h = (a * 7919 + b * 104729 + seed * 613) % 131072;
        if (h < 0) h += 131072;
        return h - 65536;
    endfunction

    // Reference spectrum merge, R1/R2.
    task automatic push_expected();
        for (int k = 0; k < N; k++) begin
            int m, b;
            longint xr, xi, yr, yi;
            m  = k % SUBN;
            b  = (2 * k) % N;
            xr = rnd16(longint'(buf_re[SUBN+m]) * tw_re[k] - longint'(buf_im[SUBN+m]) * tw_im[k]);
            xi = rnd16(longint'(buf_re[SUBN+m]) * tw_im[k] + longint'(buf_im[SUBN+m]) * tw_re[k]);
            yr = rnd16(longint'(buf_re[2*SUBN+m]) * tw_re[b] - longint'(buf_im[2*SUBN+m]) * tw_im[b]);
            yi = rnd16(longint'(buf_re[2*SUBN+m]) * tw_im[b] + longint'(buf_im[2*SUBN+m]) * tw_re[b]);
            exp_re_q.push_back(int'(buf_re[m] + xr + yr));
            exp_im_q.push_back(int'(buf_im[m] + xi + yi));
        end
    endtask

    task automatic fill_pattern(int pat);
        for (int i = 0; i < N; i++) begin
            case (pat)
                0: begin buf_re[i] = (i == SUBN) ? 32768 : 0; buf_im[i] = 0; end
                1: begin buf_re[i] = -65536; buf_im[i] = (i % 2 == 0) ? -65536 : 65535; end
                default: begin buf_re[i] = hashv(i, pat); buf_im[i] = hashv(i + 3, pat * 5); end
            endcase
        end
    endtask

    // Drive one frame (R3); optionally random idle cycles and a junk window (R7).
    task automatic send_frame(bit gaps, bit junk);
        push_expected();
        for (int i = 0; i < N; i++) begin
            if (gaps) begin
                while (hashv(i, negcnt) % 3 == 0) begin
                    @(posedge clk); #1;
                    in_valid = 1'b0; last_flag = 1'b0;
                    in_re = DW'(hashv(negcnt, 9)); in_im = DW'(hashv(negcnt, 11));
                end
            end
            @(posedge clk); #1;
            in_valid  = 1'b1;
            in_re     = DW'(buf_re[i]);
            in_im     = DW'(buf_im[i]);
            last_flag = (i == N - 1);
        end
        for (int j = 0; j < N; j++) begin
            @(posedge clk); #1;
            last_flag = 1'b0;
            in_valid  = junk;
            in_re     = DW'(hashv(j, 77));
            in_im     = DW'(hashv(j, 91));
        end
    endtask

    always @(negedge clk) begin
        negcnt++;
        if (last_flag) last_neg = negcnt;
        if (rst_n && out_valid) begin
            int er, ei;
            if (exp_re_q.size() == 0) begin
                check(1'b0, "R4 unexpected output", 1, 0);
            end else begin
                er = exp_re_q.pop_front();
                ei = exp_im_q.pop_front();
                check(int'(out_re) == er, "R1 re", longint'(out_re), er);
                check(int'(out_im) == ei, "R1 im", longint'(out_im), ei);
            end
            check(out_start == (out_idx == 0), "R5 start", out_start, out_idx == 0);
            check(out_end == (out_idx == N - 1), "R5 end", out_end, out_idx == N - 1);
            if (out_idx == 0) check(negcnt == last_neg + 4, "R6 latency", negcnt - last_neg, 4);
            out_idx = (out_idx == N - 1) ? 0 : out_idx + 1;
        end else if (rst_n && out_idx != 0) begin
            check(1'b0, "R4 gap in frame", 0, 1);
            out_idx = 0;
        end
    end

    initial begin
        for (int j = 0; j < N; j++) begin
            tw_re[j] = longint'($floor($cos(6.283185307179586 * j / N) * 65536.0 + 0.5));
            tw_im[j] = longint'($floor(-$sin(6.283185307179586 * j / N) * 65536.0 + 0.5));
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_start && !out_end, "R8 reset outputs", out_valid, 0);

        // R8: partial frame then reset, the next frame starts at P(0).
        for (int i = 0; i < 700; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_re = DW'(hashv(i, 5)); in_im = DW'(hashv(i, 6));
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(!out_valid, "R8 reset clears", out_valid, 0);
        rst_n = 1'b1;

        fill_pattern(0); send_frame(1'b0, 1'b1);   // impulse in Q, junk window R7
        fill_pattern(1); send_frame(1'b0, 1'b1);   // full-scale values
        fill_pattern(2); send_frame(1'b1, 1'b0);   // hashed data with idle cycles R3
        seed = 4;
        fill_pattern(3); send_frame(1'b1, 1'b1);
        repeat (10) @(posedge clk);
        check(exp_re_q.size() == 0, "R4 all bins produced", exp_re_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule